// File: doc/BRIEF.md
# Mode-Select Programmable Frequency Divider

This block divides its clock by a programmed integer N and emits one registered pulse, one clock wide, every N clocks. The count is held in a mixed-radix down-counter. A low nibble register is shared between a fast prescale field and a slow top field. Above it sit `NUM_DEC` cascaded decimal digit stages. Three mode pins choose the prescale modulus (10, 8, 5, 4 or 2), which sets how the low nibble is split. The same pins also select a hold state in which the counter keeps reloading the jam word.

The divisor is N = M * (T * 10^NUM_DEC + sum of digit_k * 10^k) + F. Here M is the prescale modulus, F is the prescale field and T is the top field. Each digit stage may be preset to any value from 0 to 15. The prescale field may be preset up to its full bit width, which extends the range past the nominal maximum. Every time the prescale field wraps, the digit chain and top field step down by one. When the whole count reaches one, the next clock reloads the jam word and raises the pulse. This gives a period of exactly N.

All pins are plain level controls sampled on the clock. There is no data stream and no handshake.

Top module: `divn_counter`

## Requirements
- R1: Mode pins {sel_a,sel_b,sel_c} decode as follows. 110 gives modulus 10. 111 gives 8. 011 gives 5. 101 gives 4. Both 010 and 001 give 2. 000 and 100 (sel_b = sel_c = 0) select the preset hold.
- R2: jam[3:0] is the low nibble. Its low bits form the prescale field F and its high bits form the top field T. The split is 4/0 bits for modulus 10, 3/1 for 8 and 5, 2/2 for 4, and 1/3 for 2. F may hold any value its bits allow, including values of M or more.
- R3: While counting, the pulse repeats every N = M*(T*10^NUM_DEC + sum digit_k*10^k) + F clocks, for any N of 2 or more.
- R4: Digit k is preset from jam[4k+7:4k+4] and weighted 10^k. A digit may be preset to any value 0..15. A digit that borrows at zero continues from 9.
- R5: pulse_o is registered and high for exactly one clock. After the clock edge that first counts from a fresh preset, it rises on the Nth clock edge.
- R6: In preset hold, the counter reloads the jam word on every clock and pulse_o stays low. After a counting mode is selected, counting starts from the jam value present at the last hold clock.
- R7: A synchronous active-high rst loads the jam word and drives pulse_o low. Counting from that preset begins with the first clock edge at which rst is low.
- R8: The jam word is sampled only on load clocks, which are hold, reset and terminal reload clocks. A change of the jam word in the middle of a count has no effect until the next reload.
- R9: If preset hold is selected on the clock where the count stands at one, no pulse is issued, the counter loads, and a later count takes a full N.
- R10: With the default three digits, modulus 8 with every jam bit set divides by 21327. Modulus 10, which has no top field, with every digit nibble at 9 divides by 9999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset; forces a jam load |
| sel_a | input | 1 | Mode select, first pin |
| sel_b | input | 1 | Mode select, second pin |
| sel_c | input | 1 | Mode select, third pin |
| jam | input | 4*(NUM_DEC+1) | Preset word: low nibble, then one nibble per digit stage, units first |
| pulse_o | output | 1 | One-clock pulse once every N clocks |

## Verification
Two events can land on the same clock: the terminal reload that emits a pulse, and entry into preset hold. The bench arms a known small N and waits exactly N-1 counting clocks so that the count stands at one. It then switches the mode pins to hold at that point. The test passes only if pulse_o stays low and the next release takes a full N clocks to the first pulse. A second boundary is a jam change made just after a reload. That count must finish with the old divisor and apply the new one only to the period that follows.

// File: rtl/divn_pkg.sv
package divn_pkg;

  localparam int DIGIT_W = 4;
  localparam int SHIFT_W = 3;

  typedef enum logic [2:0] {
    MD_HOLD,
    MD_DIV10,
    MD_DIV8,
    MD_DIV5,
    MD_DIV4,
    MD_DIV2
  } div_mode_e;

  // R1: pin pattern {a,b,c} to prescale mode
  function automatic div_mode_e decode_mode(input logic a, input logic b, input logic c);
    case ({a, b, c})
      3'b110:         return MD_DIV10;
      3'b111:         return MD_DIV8;
      3'b011:         return MD_DIV5;
      3'b101:         return MD_DIV4;
      3'b010, 3'b001: return MD_DIV2;
      default:        return MD_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/divn_mode_dec.sv
module divn_mode_dec
  import divn_pkg::*;
(
  input  logic               sel_a,
  input  logic               sel_b,
  input  logic               sel_c,
  output logic               run,
  output logic [DIGIT_W-1:0] mod_m1,
  output logic [DIGIT_W-1:0] fmask,
  output logic [SHIFT_W-1:0] fbits
);

  div_mode_e mode;

  always_comb begin
    mode   = decode_mode(sel_a, sel_b, sel_c);
    run    = 1'b1;
    mod_m1 = 4'd9;
    fmask  = 4'hF;
    fbits  = 3'd4;
    case (mode)
      MD_DIV10: begin
        mod_m1 = 4'd9;
        fmask  = 4'hF;
        fbits  = 3'd4;
      end
      MD_DIV8: begin
        mod_m1 = 4'd7;
        fmask  = 4'h7;
        fbits  = 3'd3;
      end
      MD_DIV5: begin
        mod_m1 = 4'd4;
        fmask  = 4'h7;
        fbits  = 3'd3;
      end
      MD_DIV4: begin
        mod_m1 = 4'd3;
        fmask  = 4'h3;
        fbits  = 3'd2;
      end
      MD_DIV2: begin
        mod_m1 = 4'd1;
        fmask  = 4'h1;
        fbits  = 3'd1;
      end
      default: run = 1'b0;
    endcase
  end

endmodule

// File: rtl/divn_low_sec.sv
module divn_low_sec
  import divn_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic               last_dec,
  input  logic [DIGIT_W-1:0] preset,
  input  logic [DIGIT_W-1:0] mod_m1,
  input  logic [DIGIT_W-1:0] fmask,
  input  logic [SHIFT_W-1:0] fbits,
  output logic [DIGIT_W-1:0] lo_q,
  output logic               f_zero,
  output logic               f_le1,
  output logic               l_zero
);

  logic [DIGIT_W-1:0] f_cur, l_cur, f_nxt, l_nxt, lo_nxt;

  // The nibble is stored raw; the mode decides which bits are prescale and which are top field.
  always_comb begin
    f_cur  = lo_q & fmask;
    l_cur  = lo_q >> fbits;
    f_zero = (f_cur == 4'd0);
    f_le1  = (f_cur <= 4'd1);
    l_zero = (l_cur == 4'd0);
    f_nxt  = f_zero ? mod_m1 : (f_cur - 4'd1);
    l_nxt  = last_dec ? (l_cur - 4'd1) : l_cur;
    lo_nxt = (l_nxt << fbits) | (f_nxt & fmask);
  end

  always_ff @(posedge clk) begin
    if (load)      lo_q <= preset;
    else if (step) lo_q <= lo_nxt;
  end

  // R3: prescale field restarts at modulus-1 after it reaches zero
  a_r3_prescale_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !load && f_zero) |=> ((lo_q & $past(fmask)) == ($past(mod_m1) & $past(fmask))));

endmodule

// File: rtl/divn_decade.sv
module divn_decade
  import divn_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               dec_in,
  input  logic [DIGIT_W-1:0] preset,
  output logic               zero,
  output logic               dec_out
);

  logic [DIGIT_W-1:0] digit_q;

  assign zero    = (digit_q == 4'd0);
  assign dec_out = dec_in & zero;

  always_ff @(posedge clk) begin
    if (load)        digit_q <= preset;
    else if (dec_in) digit_q <= zero ? 4'd9 : (digit_q - 4'd1);
  end

  // R4: a borrow at zero continues from nine
  a_r4_borrow_to_nine: assert property (@(posedge clk) disable iff (rst)
    (dec_in && !load && zero) |=> (digit_q == 4'd9));

  // R8: between loads the digit only moves on a borrow request
  a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
    (!dec_in && !load) |=> $stable(digit_q));

endmodule

// File: rtl/divn_counter.sv
module divn_counter
  import divn_pkg::*;
#(
  parameter  int NUM_DEC = 3,
  localparam int JAM_W   = DIGIT_W * (NUM_DEC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c,
  input  logic [JAM_W-1:0] jam,
  output logic             pulse_o
);

  logic               run;
  logic [DIGIT_W-1:0] mod_m1, fmask;
  logic [SHIFT_W-1:0] fbits;
  logic [DIGIT_W-1:0] lo_q;
  logic               f_zero, f_le1, l_zero;
  logic [NUM_DEC:0]   borrow;
  logic [NUM_DEC-1:0] dig_zero;
  logic               term, load, step;

  divn_mode_dec u_mode (
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .sel_c  (sel_c),
    .run    (run),
    .mod_m1 (mod_m1),
    .fmask  (fmask),
    .fbits  (fbits)
  );

  // The count stands at one: reload on the next edge, so the period is exactly N.
  assign term      = run & f_le1 & l_zero & (&dig_zero);
  assign load      = rst | ~run | term;
  assign step      = ~load;
  assign borrow[0] = step & f_zero;

  divn_low_sec u_low (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .last_dec (borrow[NUM_DEC]),
    .preset   (jam[DIGIT_W-1:0]),
    .mod_m1   (mod_m1),
    .fmask    (fmask),
    .fbits    (fbits),
    .lo_q     (lo_q),
    .f_zero   (f_zero),
    .f_le1    (f_le1),
    .l_zero   (l_zero)
  );

  for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
    divn_decade u_dec (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .dec_in  (borrow[k]),
      .preset  (jam[DIGIT_W*(k+1) +: DIGIT_W]),
      .zero    (dig_zero[k]),
      .dec_out (borrow[k+1])
    );
  end

  always_ff @(posedge clk) begin
    pulse_o <= ~rst & term;
  end

  // R6: hold mode never produces a pulse
  a_r6_quiet_in_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pulse_o);

  // R5: every pulse coincides with a fresh load of the jam nibble
  a_r5_pulse_marks_reload: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (lo_q == $past(jam[DIGIT_W-1:0])));

endmodule

// File: tb/sim_divn_counter.sv
module sim_divn_counter;

  localparam int CLK_PERIOD = 10;
  localparam int SMALL_DEC  = 1;
  localparam int WD_CYCLES  = 195000;
  localparam int MEAS_LIM   = 30000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sa = 1'b1, sb = 1'b1, sc = 1'b0;
  logic [7:0]  jam0 = 8'h00;
  logic [15:0] jam1 = 16'h0000;
  logic        p0, p1;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  divn_counter #(.NUM_DEC(SMALL_DEC)) u0 (
    .clk(clk), .rst(rst), .sel_a(sa), .sel_b(sb), .sel_c(sc), .jam(jam0), .pulse_o(p0)
  );

  divn_counter u1 (
    .clk(clk), .rst(rst), .sel_a(sa), .sel_b(sb), .sel_c(sc), .jam(jam1), .pulse_o(p1)
  );

  function automatic int mod_of(input logic [2:0] k);
    case (k)
      3'b110:         return 10;
      3'b111:         return 8;
      3'b011:         return 5;
      3'b101:         return 4;
      3'b010, 3'b001: return 2;
      default:        return 0;
    endcase
  endfunction

  function automatic int fbits_of(input int m);
    if (m == 10) return 4;
    if (m == 8 || m == 5) return 3;
    if (m == 4) return 2;
    return 1;
  endfunction

  function automatic logic [2:0] mode_code(input int i);
    case (i)
      0: return 3'b110;
      1: return 3'b111;
      2: return 3'b011;
      3: return 3'b101;
      default: return 3'b010;
    endcase
  endfunction

  // N from the divisor formula of R2, R3 and R4
  function automatic int expect_n(input logic [2:0] k, input logic [15:0] j, input int ndec);
    int m, fb, nib, f, t, up, w;
    m   = mod_of(k);
    fb  = fbits_of(m);
    nib = int'(j[3:0]);
    f   = nib % (1 << fb);
    t   = nib >> fb;
    up  = 0;
    w   = 1;
    for (int i = 0; i < ndec; i++) begin
      up += int'(j[4*i+4 +: 4]) * w;
      w  *= 10;
    end
    up += t * w;
    return m * up + f;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts clock edges until the pulse is seen; called and returns at a falling edge.
  task automatic measure(input int which, output int cyc);
    bit hit;
    hit = 1'b0;
    cyc = 0;
    while (!hit && cyc < MEAS_LIM) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      hit = (which == 0) ? p0 : p1;
    end
  endtask

  task automatic arm(input logic [2:0] k, input logic [7:0] j0, input logic [15:0] j1);
    {sa, sb, sc} = 3'b000;
    jam0 = j0;
    jam1 = j1;
    repeat (2) @(negedge clk);
    {sa, sb, sc} = k;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: got %0d cycles expected fewer", WD_CYCLES);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c, v, v2;
    logic [7:0] j;

    // R7: reset holds the pulse low, then counting starts from the jam word
    jam0 = {4'd1, 4'd2};
    repeat (4) begin
      @(negedge clk);
      check("R7 pulse low in reset", int'(p0), 0);
    end
    rst = 1'b0;
    measure(0, c);
    check("R7 first pulse after reset", c, expect_n(3'b110, {8'h00, jam0}, SMALL_DEC));

    // R6: hold keeps reloading; the last value held is the start point
    {sa, sb, sc} = 3'b000;
    jam0 = {4'd3, 4'd6};
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R6 pulse low in hold", int'(p0), 0);
      if (i == 10) jam0 = {4'd2, 4'd9};
    end
    {sa, sb, sc} = 3'b100;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 R6 pattern 100 holds", int'(p0), 0);
    end
    {sa, sb, sc} = 3'b111;
    measure(0, c);
    check("R6 count from last held jam", c, expect_n(3'b111, {8'h00, jam0}, SMALL_DEC));

    // R9: hold selected on the terminal clock
    arm(3'b110, {4'd0, 4'd7}, jam1);
    v = expect_n(3'b110, {8'h00, 4'd0, 4'd7}, SMALL_DEC);
    repeat (v - 1) @(negedge clk);
    {sa, sb, sc} = 3'b000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 no pulse when hold meets terminal", int'(p0), 0);
    end
    {sa, sb, sc} = 3'b110;
    measure(0, c);
    check("R9 full count after release", c, v);

    // R8: jam change mid-count applies only after the next reload
    arm(3'b101, {4'd2, 4'd6}, jam1);
    v  = expect_n(3'b101, {8'h00, 4'd2, 4'd6}, SMALL_DEC);
    v2 = expect_n(3'b101, {8'h00, 4'd1, 4'd11}, SMALL_DEC);
    measure(0, c);
    check("R8 first period", c, v);
    jam0 = {4'd1, 4'd11};
    measure(0, c);
    check("R8 running period keeps old jam", c, v);
    measure(0, c);
    check("R8 new jam after reload", c, v2);

    // R1: pattern 001 divides by two in the prescaler
    arm(3'b001, {4'd3, 4'd5}, jam1);
    v = expect_n(3'b001, {8'h00, 4'd3, 4'd5}, SMALL_DEC);
    measure(0, c);
    check("R1 pattern 001 first pulse", c, v);
    measure(0, c);
    check("R1 pattern 001 period", c, v);

    // R2 R3 R4 R5: sweep every nibble split in every mode, digits across 0..15
    for (int mi = 0; mi < 5; mi++) begin
      for (int nib = 0; nib < 16; nib++) begin
        for (int d = 0; d < 16; d += 5) begin
          j = {d[3:0], nib[3:0]};
          v = expect_n(mode_code(mi), {8'h00, j}, SMALL_DEC);
          if (v >= 2) begin
            arm(mode_code(mi), j, jam1);
            measure(0, c);
            check("R2 R3 R4 first pulse after N", c, v);
            measure(0, c);
            check("R3 R5 one-wide pulse period", c, v);
          end
        end
      end
    end

    // R10: full three-digit instance at the range ends
    arm(3'b111, jam0, 16'hFFFF);
    measure(1, c);
    check("R10 divide-by-8 extended maximum", c, 21327);
    arm(3'b110, jam0, 16'h9999);
    measure(1, c);
    check("R10 divide-by-10 nominal maximum", c, 9999);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule